// File: doc/BRIEF.md
# Character Console Register Block

This block sits on a simple processor bus and gives software two byte-wide channels to a character terminal. On the input side, a keyboard front end presents a character code with a one-cycle valid pulse. The block captures the code, raises a ready flag and keeps it raised until software reads the character. On the output side, software writes a character code. The block presents it to the display front end with a valid/ready handshake and reports itself busy until the display has taken the character.

Software sees four byte registers at consecutive addresses starting at a parameterised base. Offset 0 holds the received character, offset 1 is the receive status, offset 2 is the transmit character and offset 3 is the transmit status. Both ready flags sit at bit 3 of their status byte, and the receive status also carries a sticky overrun flag at bit 7. The flags are never written by software. Accesses to the data registers clear them as a side effect. A polling driver therefore needs only a bit test on the status byte and a data access. Each bus access takes one cycle, and read data is registered.

Top module: `char_io_regs`

## Requirements
- R1: A cycle with `kb_valid` high stores `kb_char` in the receive data register, and a later read of offset 0 returns that code.
- R2: The receive ready flag (bit 3 of offset 1) is 0 after reset and is 1 from the cycle after a character arrives.
- R3: A read of offset 0 clears the receive ready flag. If a character arrives in the same cycle, the read returns the old code, the new code is stored and the flag stays 1 with no overrun.
- R4: A character that arrives while the receive ready flag is 1, with no read of offset 0 in that cycle, overwrites the stored code and sets the overrun flag (bit 7 of offset 1). Overrun stays set until a read of offset 1 returns it, and that read clears it. A new overrun in the same cycle keeps it set.
- R5: The transmit ready flag (bit 3 of offset 3) is 1 after reset. A write to offset 2 while it is 1 drives the written code on `disp_char` with `disp_valid` high from the next cycle and clears the flag.
- R6: `disp_valid` and `disp_char` hold until a cycle with `disp_ready` high. `disp_valid` is low from the next cycle, and the transmit ready flag returns to 1 one cycle after that.
- R7: A write to offset 2 while the transmit ready flag is 0 is dropped: `disp_char` and the value read back from offset 2 are unchanged.
- R8: Writes to offsets 0, 1 and 3 change no register.
- R9: A read of offset 2 returns the last accepted transmit code (0 after reset).
- R10: A read puts its data on `bus_rdata` in the following cycle and reflects the state before that read's clock edge. Status bits other than 3 and receive bit 7 read as 0. `bus_rdata` is 0 after any cycle without a read.
- R11: Only addresses `BASE_ADDR` to `BASE_ADDR+3` are decoded. An access outside that window returns 0 and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| kb_valid | input | 1 | Keyboard character strobe |
| kb_char | input | DATA_W | Keyboard character code |
| disp_ready | input | 1 | Display accepts the presented character |
| disp_valid | output | 1 | Character presented to the display |
| disp_char | output | DATA_W | Character code to the display |

## Verification
The bench targets the cycles where two events collide. One is a data read meeting a new keystroke: a design that favours the read loses the character, and one that flags overrun there reports a false error. Another is a status read meeting a second overrun: a wrong design clears a flag that should stay set. The bench also writes while the display is busy, where a faulty block replaces a character the display is still holding. It times the ready return exactly after the handshake, so an early or late flag shows up on a status read. Out-of-window and status-register writes are followed by reads, which shows whether a faulty decode touched the state.

// File: rtl/char_io_pkg.sv
package char_io_pkg;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned OFS_W    = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_RX_DATA = 2'd0,
    OFS_RX_STAT = 2'd1,
    OFS_TX_DATA = 2'd2,
    OFS_TX_STAT = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/cio_addr_dec.sv
module cio_addr_dec
  import char_io_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_REGS-1:0] rd_strb,
  output logic [NUM_REGS-1:0] wr_strb
);
  localparam int unsigned TAG_W = ADDR_W - OFS_W;

  logic             win_hit;
  logic [OFS_W-1:0] ofs;

  assign win_hit = bus_sel && (bus_addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign ofs     = bus_addr[OFS_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_strb
    assign rd_strb[i] = win_hit && !bus_we && (ofs == OFS_W'(i));
    assign wr_strb[i] = win_hit &&  bus_we && (ofs == OFS_W'(i));
  end

  initial begin
    AST_BASE_ALIGNED: assert (BASE_ADDR[OFS_W-1:0] == '0) // R11
      else $error("base address not aligned to register window");
    AST_TAG_WIDTH: assert (TAG_W > 0) // R11
      else $error("address too narrow");
  end
endmodule

// File: rtl/cio_kbd_side.sv
module cio_kbd_side #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RDY_BIT = 3,
  parameter int unsigned OVR_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kb_valid,
  input  logic [DATA_W-1:0] kb_char,
  input  logic              rd_data_strb,
  input  logic              rd_stat_strb,
  output logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] rx_stat
);
  logic rdy_q;
  logic ovr_q;
  logic overrun_now;

  // a fresh code lost only if the previous one was unread and not read now
  assign overrun_now = kb_valid && rdy_q && !rd_data_strb;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rdy_q   <= 1'b0;
    end else if (kb_valid) begin
      rx_data <= kb_char;
      rdy_q   <= 1'b1;
    end else if (rd_data_strb) begin
      rdy_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              ovr_q <= 1'b0;
    else if (overrun_now) ovr_q <= 1'b1;
    else if (rd_stat_strb) ovr_q <= 1'b0;
  end

  always_comb begin
    rx_stat          = '0;
    rx_stat[RDY_BIT] = rdy_q;
    rx_stat[OVR_BIT] = ovr_q;
  end

  AST_CHAR_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    kb_valid |=> (rx_data == $past(kb_char)) && rdy_q) // R1
    else $error("keyboard code not captured");
  AST_RDY_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!kb_valid && !rd_data_strb) |=> $stable(rdy_q)) // R2
    else $error("receive ready changed without cause");
  AST_READ_CLEARS_RDY: assert property (@(posedge clk) disable iff (rst)
    (rd_data_strb && !kb_valid) |=> !rdy_q) // R3
    else $error("data read left receive ready set");
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (kb_valid && rdy_q && !rd_data_strb) |=> ovr_q) // R4
    else $error("overrun not flagged");
  AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !rd_stat_strb) |=> ovr_q) // R4
    else $error("overrun flag lost");
endmodule

// File: rtl/cio_disp_side.sv
module cio_disp_side #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RDY_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data_strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_char,
  output logic [DATA_W-1:0] tx_stat
);
  logic rdy_q;
  logic ack_pend_q;
  logic launch;
  logic ack;

  assign launch = wr_data_strb && rdy_q;
  assign ack    = disp_valid && disp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_char <= '0;
    end else if (launch) begin
      disp_char <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      ack_pend_q <= 1'b0;
      rdy_q      <= 1'b1;
    end else begin
      ack_pend_q <= ack;
      if (launch) begin
        disp_valid <= 1'b1;
        rdy_q      <= 1'b0;
      end else begin
        if (ack)        disp_valid <= 1'b0;
        if (ack_pend_q) rdy_q      <= 1'b1;
      end
    end
  end

  always_comb begin
    tx_stat          = '0;
    tx_stat[RDY_BIT] = rdy_q;
  end

  AST_WRITE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (wr_data_strb && rdy_q) |=> disp_valid && !rdy_q && (disp_char == $past(wdata))) // R5
    else $error("accepted write not presented");
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready) |=> disp_valid && $stable(disp_char)) // R6
    else $error("display character dropped before acceptance");
  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready) |=> !disp_valid && !rdy_q ##1 rdy_q) // R6
    else $error("transmit ready timing wrong");
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_data_strb && !rdy_q) |=> $stable(disp_char)) // R7
    else $error("busy write altered display code");
endmodule

// File: rtl/char_io_regs.sv
module char_io_regs
  import char_io_pkg::*;
#(
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter int unsigned       RDY_BIT   = 3,
  parameter int unsigned       OVR_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [DATA_W-1:0] kb_char,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_char
);
  localparam logic [DATA_W-1:0] RX_STAT_MASK = DATA_W'((1 << RDY_BIT) | (1 << OVR_BIT));
  localparam logic [DATA_W-1:0] TX_STAT_MASK = DATA_W'(1 << RDY_BIT);

  logic [NUM_REGS-1:0] rd_strb;
  logic [NUM_REGS-1:0] wr_strb;
  logic [DATA_W-1:0]   rx_data;
  logic [DATA_W-1:0]   rx_stat;
  logic [DATA_W-1:0]   tx_stat;
  logic [DATA_W-1:0]   rd_mux;

  cio_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .rd_strb (rd_strb),
    .wr_strb (wr_strb)
  );

  cio_kbd_side #(.DATA_W(DATA_W), .RDY_BIT(RDY_BIT), .OVR_BIT(OVR_BIT)) u_kbd (
    .clk         (clk),
    .rst         (rst),
    .kb_valid    (kb_valid),
    .kb_char     (kb_char),
    .rd_data_strb(rd_strb[OFS_RX_DATA]),
    .rd_stat_strb(rd_strb[OFS_RX_STAT]),
    .rx_data     (rx_data),
    .rx_stat     (rx_stat)
  );

  cio_disp_side #(.DATA_W(DATA_W), .RDY_BIT(RDY_BIT)) u_disp (
    .clk         (clk),
    .rst         (rst),
    .wr_data_strb(wr_strb[OFS_TX_DATA]),
    .wdata       (bus_wdata),
    .disp_ready  (disp_ready),
    .disp_valid  (disp_valid),
    .disp_char   (disp_char),
    .tx_stat     (tx_stat)
  );

  // one-hot strobes make this an AND-OR, zero when nothing is read
  always_comb begin
    rd_mux = ({DATA_W{rd_strb[OFS_RX_DATA]}}  & rx_data)
           | ({DATA_W{rd_strb[OFS_RX_STAT]}}  & rx_stat)
           | ({DATA_W{rd_strb[OFS_TX_DATA]}}  & disp_char)
           | ({DATA_W{rd_strb[OFS_TX_STAT]}}  & tx_stat);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  AST_STROBES_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_strb, wr_strb})) // R11
    else $error("more than one register strobed");
  AST_RX_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_strb[OFS_RX_STAT]) |-> ((bus_rdata & ~RX_STAT_MASK) == '0)) // R10
    else $error("receive status spare bits set");
  AST_TX_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_strb[OFS_TX_STAT]) |-> ((bus_rdata & ~TX_STAT_MASK) == '0)) // R10
    else $error("transmit status spare bits set");
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(|rd_strb) |-> (bus_rdata == '0)) // R10
    else $error("read data nonzero without read");
endmodule

// File: tb/tb_char_io_regs.sv
`timescale 1ns/1ps
module tb_char_io_regs;
  localparam logic [15:0] BASE = 16'h0040;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       kb_valid = 1'b0;
  logic [7:0] kb_char = '0;
  logic       disp_ready = 1'b0, disp_valid;
  logic [7:0] disp_char;

  int checks = 0, failures = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  char_io_regs #(.BASE_ADDR(BASE)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kb_valid(kb_valid), .kb_char(kb_char),
    .disp_ready(disp_ready), .disp_valid(disp_valid), .disp_char(disp_char)
  );

  // behavioural reference
  logic [7:0] m_rx, m_tx, m_rdata;
  bit m_rx_rdy, m_ovr, m_tx_rdy, m_pend, m_dvalid;

  always @(posedge clk) begin
    int ofs;
    bit hit, rd, wr;
    hit = (bus_addr >= BASE) && (bus_addr < BASE + 16'd4) && bus_sel;
    ofs = int'(bus_addr - BASE);
    rd  = hit && !bus_we;
    wr  = hit && bus_we;
    if (rst) begin
      m_rx <= 0; m_tx <= 0; m_rdata <= 0; m_rx_rdy <= 0; m_ovr <= 0;
      m_tx_rdy <= 1; m_pend <= 0; m_dvalid <= 0;
    end else begin
      if (!rd) m_rdata <= 0;
      else case (ofs)
        0: m_rdata <= m_rx;
        1: m_rdata <= {m_ovr, 3'b000, m_rx_rdy, 3'b000};
        2: m_rdata <= m_tx;
        default: m_rdata <= {4'b0000, m_tx_rdy, 3'b000};
      endcase
      if (kb_valid) begin
        m_rx <= kb_char; m_rx_rdy <= 1;
        if (m_rx_rdy && !(rd && ofs == 0)) m_ovr <= 1;
        else if (rd && ofs == 1) m_ovr <= 0;
      end else begin
        if (rd && ofs == 0) m_rx_rdy <= 0;
        if (rd && ofs == 1) m_ovr <= 0;
      end
      m_pend <= m_dvalid && disp_ready;
      if (wr && ofs == 2 && m_tx_rdy) begin
        m_tx <= bus_wdata; m_dvalid <= 1; m_tx_rdy <= 0;
      end else begin
        if (m_dvalid && disp_ready) m_dvalid <= 0;
        if (m_pend) m_tx_rdy <= 1;
      end
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R10 model bus_rdata", bus_rdata, m_rdata);
      chk("R6 model disp_valid", {7'b0, disp_valid}, {7'b0, m_dvalid});
      chk("R5 model disp_char", disp_char, m_tx);
    end
  end

  task automatic bus_op(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                        output logic [7:0] rd);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    rd = bus_rdata;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd_chk(string tag, input int ofs, input logic [7:0] exp);
    logic [7:0] v;
    bus_op(1'b0, BASE + 16'(ofs), 8'h00, v);
    chk(tag, v, exp);
  endtask

  task automatic wr(input int ofs, input logic [7:0] d);
    logic [7:0] v;
    bus_op(1'b1, BASE + 16'(ofs), d, v);
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk);
    kb_valid = 1; kb_char = c;
    @(negedge clk);
    kb_valid = 0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    model_on = 1;
    // reset state
    rd_chk("R2 rx status after reset", 1, 8'h00);
    rd_chk("R5 tx status after reset", 3, 8'h08);
    rd_chk("R9 tx data after reset", 2, 8'h00);
    chk("R5 disp_valid after reset", {7'b0, disp_valid}, 8'h00);
    // receive path
    key(8'h41);
    rd_chk("R2 rx ready set", 1, 8'h08);
    rd_chk("R1 rx data", 0, 8'h41);
    rd_chk("R3 rx ready cleared by read", 1, 8'h00);
    // overrun
    key(8'h31); key(8'h32);
    rd_chk("R4 overwritten code", 0, 8'h32);
    rd_chk("R4 overrun flagged", 1, 8'h80);
    rd_chk("R4 overrun cleared by status read", 1, 8'h00);
    // writes to other registers ignored
    wr(0, 8'hFF); wr(1, 8'hFF); wr(3, 8'h00);
    rd_chk("R8 rx data untouched", 0, 8'h32);
    rd_chk("R8 rx status untouched", 1, 8'h00);
    rd_chk("R8 tx status untouched", 3, 8'h08);
    chk("R8 no display launch", {7'b0, disp_valid}, 8'h00);
    // transmit path
    wr(2, 8'h5A);
    chk("R5 disp_valid raised", {7'b0, disp_valid}, 8'h01);
    chk("R5 disp_char", disp_char, 8'h5A);
    rd_chk("R5 tx ready cleared", 3, 8'h00);
    wr(2, 8'h77);
    chk("R7 busy write dropped", disp_char, 8'h5A);
    rd_chk("R7 R9 tx data readback", 2, 8'h5A);
    chk("R6 valid held", {7'b0, disp_valid}, 8'h01);
    // handshake timing
    @(negedge clk);
    disp_ready = 1;
    @(negedge clk);
    disp_ready = 0;
    chk("R6 valid dropped after ack", {7'b0, disp_valid}, 8'h00);
    bus_sel = 1; bus_we = 0; bus_addr = BASE + 16'd3;
    @(negedge clk);
    chk("R6 tx ready still low one cycle", bus_rdata, 8'h00);
    @(negedge clk);
    chk("R6 tx ready back", bus_rdata, 8'h08);
    bus_sel = 0;
    rd_chk("R9 tx data after completion", 2, 8'h5A);
    // out of window
    key(8'h55);
    rd_chk("R11 above window", 4, 8'h00);
    bus_op(1'b0, BASE - 16'd1, 8'h00, v);
    chk("R11 below window", v, 8'h00);
    bus_op(1'b1, BASE + 16'd6, 8'h99, v);
    chk("R11 alias write no launch", {7'b0, disp_valid}, 8'h00);
    rd_chk("R11 rx ready not cleared", 1, 8'h08);
    rd_chk("R11 rx data intact", 0, 8'h55);
    // read and arrival in same cycle
    key(8'h61);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = BASE; kb_valid = 1; kb_char = 8'h62;
    @(negedge clk);
    chk("R3 read returns old code", bus_rdata, 8'h61);
    bus_sel = 0; kb_valid = 0;
    rd_chk("R3 ready kept, no overrun", 1, 8'h08);
    rd_chk("R3 new code stored", 0, 8'h62);
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      bus_sel    = ($urandom_range(0, 2) == 0);
      bus_we     = $urandom_range(0, 1);
      bus_addr   = BASE - 16'd1 + 16'($urandom_range(0, 5));
      bus_wdata  = 8'($urandom);
      kb_valid   = ($urandom_range(0, 6) == 0);
      kb_char    = 8'($urandom);
      disp_ready = ($urandom_range(0, 2) == 0);
    end
    @(negedge clk);
    bus_sel = 0; kb_valid = 0; disp_ready = 0;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule